// File: doc/BRIEF.md
# I2C Bus Start/Stop Watcher

This block listens passively to the two wires of an I2C bus and tracks whether a transfer is open. It first brings SCL and SDA into the local clock domain through a chain of flip-flops. It then looks for the two framing conditions. An SDA fall while SCL is high opens a transfer. An SDA rise while SCL is high closes it.

Two mutually exclusive status bits record which condition came last. A bus-free output tells software that it may try to become master. This is the case after a closing condition, and also when neither condition has been seen since reset or since the block was last switched on.

A sticky event flag collects every framing condition and every byte-complete strobe that the byte engine supplies. Software clears the flag with a one-cycle strobe. The flag is gated by an interrupt enable before it reaches the interrupt pin. Turning the interrupt enable on in the middle of a transfer therefore produces a request no earlier than the next flag-setting event, which is normally the closing condition.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, `start_seen`, `stop_seen`, `irq_flag` and `irq` are 0 and `bus_free` is 1.
- R2: An SDA fall while SCL stays high sets `start_seen` and clears `stop_seen`. An SDA rise while SCL stays high sets `stop_seen` and clears `start_seen`. SDA changes while SCL is low, and SCL changes, alter neither bit. The two bits are never 1 together.
- R3: `bus_free` is 1 exactly when `stop_seen` is 1 or both status bits are 0.
- R4: Every opening condition and every closing condition sets `irq_flag`.
- R5: A `byte_done` pulse while `en` is 1 sets `irq_flag` on the next clock edge.
- R6: An opening condition seen while `start_seen` is already 1 sets `irq_flag` again and leaves `start_seen` at 1.
- R7: `irq_flag` holds until an `irq_clr` pulse. If a flag-setting event coincides with `irq_clr`, the flag stays 1.
- R8: `irq` equals `irq_flag` AND `irq_en`. If `irq_en` rises while `irq_flag` is 0 during a transfer, `irq` stays 0 until the next closing condition.
- R9: While `en` is 0, both status bits and `irq_flag` read 0 from the next clock edge on. Bus conditions and `byte_done` have no effect during that time.
- R10: A framing condition is visible on the status outputs no later than SYNC_STAGES+2 clock edges after the SDA edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock wire level, asynchronous |
| sda_in | input | 1 | Bus data wire level, asynchronous |
| en | input | 1 | Module enable; 0 clears and freezes the state |
| byte_done | input | 1 | One-cycle strobe: a byte was sent or received |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | One-cycle strobe that clears the event flag |
| start_seen | output | 1 | The last framing condition was an opening one |
| stop_seen | output | 1 | The last framing condition was a closing one |
| bus_free | output | 1 | Software may try to claim the bus |
| irq_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks through every ordered pair of wire levels, starting from each of the four bus states. This catches a detector that reacts to SDA moving under a low SCL, or to SCL and SDA moving together; such a design would report phantom transfers. Repeated opening conditions check that a design which toggles the start bit, instead of setting it, loses the busy state. A clear strobe that coincides with a byte strobe exposes a design that gives the clear priority and drops the event. Enabling the interrupt mid-transfer, and stimulating the bus while the block is disabled, expose early requests and state leaking through the enable.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  // Framing conditions decoded from the synchronized wires
  typedef struct packed {
    logic open_c;   // SDA fell while SCL high
    logic close_c;  // SDA rose while SCL high
  } frame_ev_t;

  // Bit positions of the packed wire bus {scl, sda}
  localparam int unsigned WIRE_SCL = 1;
  localparam int unsigned WIRE_SDA = 0;
  localparam int unsigned WIRE_W   = 2;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_in;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/i2cmon_cond_det.sv
module i2cmon_cond_det
  import i2cmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIRE_W-1:0] wire_s,
  output frame_ev_t         ev
);

  logic [WIRE_W-1:0] prev_q;
  logic [WIRE_W-1:0] prev_d;
  logic              scl_held;

  always_comb begin
    prev_d   = wire_s;
    scl_held = wire_s[WIRE_SCL] & prev_q[WIRE_SCL];
    ev.open_c  = scl_held & prev_q[WIRE_SDA] & ~wire_s[WIRE_SDA];
    ev.close_c = scl_held & ~prev_q[WIRE_SDA] & wire_s[WIRE_SDA];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/i2cmon_status.sv
module i2cmon_status
  import i2cmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  frame_ev_t ev,
  input  logic      byte_done,
  input  logic      irq_clr,
  output logic      open_q,
  output logic      close_q,
  output logic      flag_q
);

  logic open_d, close_d, flag_d;
  logic st_ce, flag_ce, flag_set;

  always_comb begin
    open_d   = open_q;
    close_d  = close_q;
    flag_set = ev.open_c | ev.close_c | byte_done;
    if (!en) begin
      open_d  = 1'b0;
      close_d = 1'b0;
      flag_d  = 1'b0;
    end else begin
      if (ev.open_c) begin
        open_d  = 1'b1;
        close_d = 1'b0;
      end else if (ev.close_c) begin
        open_d  = 1'b0;
        close_d = 1'b1;
      end
      flag_d = flag_set | (flag_q & ~irq_clr);
    end
    st_ce   = ~en | ev.open_c | ev.close_c;
    flag_ce = ~en | flag_set | irq_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      close_q <= 1'b0;
    end else if (st_ce) begin
      open_q  <= open_d;
      close_q <= close_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2cmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic en,
  input  logic byte_done,
  input  logic irq_en,
  input  logic irq_clr,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic irq_flag,
  output logic irq
);

  logic [WIRE_W-1:0] wire_raw;
  logic [WIRE_W-1:0] wire_s;
  frame_ev_t         ev;

  assign wire_raw[WIRE_SCL] = scl_in;
  assign wire_raw[WIRE_SDA] = sda_in;

  i2cmon_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (WIRE_W),
    .RST_VAL('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (wire_raw),
    .q_out(wire_s)
  );

  i2cmon_cond_det u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .wire_s(wire_s),
    .ev    (ev)
  );

  i2cmon_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ev       (ev),
    .byte_done(byte_done),
    .irq_clr  (irq_clr),
    .open_q   (start_seen),
    .close_q  (stop_seen),
    .flag_q   (irq_flag)
  );

  assign bus_free = stop_seen | ~(start_seen | stop_seen);
  assign irq      = irq_flag & irq_en;

endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic byte_done,
  input logic irq_clr,
  input logic start_seen,
  input logic stop_seen,
  input logic bus_free,
  input logic irq_flag
);

  // R2
  excl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  // R3
  free_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free == (stop_seen || !start_seen));

  // R4
  open_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_seen) |-> irq_flag);

  // R4
  close_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> irq_flag);

  // R5
  byte_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && byte_done) |=> irq_flag);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && irq_flag && !irq_clr) |=> irq_flag);

  // R9
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!start_seen && !stop_seen && !irq_flag));

endmodule

bind i2c_bus_watch i2cmon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .byte_done (byte_done),
  .irq_clr   (irq_clr),
  .start_seen(start_seen),
  .stop_seen (stop_seen),
  .bus_free  (bus_free),
  .irq_flag  (irq_flag)
);

// File: tb/sim_i2c_bus_watch.sv
`timescale 1ns/1ps
module sim_i2c_bus_watch;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC_ST    = 2;
  localparam int SETTLE     = SYNC_ST + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic en = 1'b0, byte_done = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic start_seen, stop_seen, bus_free, irq_flag, irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // reference model
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic m_open = 1'b0, m_close = 1'b0, m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_watch #(.SYNC_STAGES(SYNC_ST)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .en(en), .byte_done(byte_done), .irq_en(irq_en), .irq_clr(irq_clr),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .irq_flag(irq_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " start_seen"}, start_seen, m_open);
    chk({req, " stop_seen"},  stop_seen,  m_close);
    chk({req, " R3 bus_free"}, bus_free,  m_close | ~(m_open | m_close));
    chk({req, " irq_flag"},   irq_flag,   m_flag);
    chk({req, " R8 irq"},     irq,        m_flag & irq_en);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // move the wires, update the model, wait, check
  task automatic move(input logic nscl, input logic nsda, input string req);
    logic ev_o, ev_c;
    ev_o = m_scl & nscl & m_sda & ~nsda;
    ev_c = m_scl & nscl & ~m_sda & nsda;
    if (en) begin
      if (ev_o) begin m_open = 1'b1; m_close = 1'b0; end
      else if (ev_c) begin m_open = 1'b0; m_close = 1'b1; end
      if (ev_o | ev_c) m_flag = 1'b1;
    end
    m_scl = nscl; m_sda = nsda;
    @(negedge clk);
    scl_in = nscl; sda_in = nsda;
    wait_cyc(SETTLE);
    check_all(req);
  endtask

  task automatic pulse_clr(input string req);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    if (en) m_flag = 1'b0;
    chk({req, " R7 clear"}, irq_flag, m_flag);
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 reset start", start_seen, 1'b0);
    chk("R1 reset stop",  stop_seen,  1'b0);
    chk("R1 reset flag",  irq_flag,   1'b0);
    chk("R1 reset irq",   irq,        1'b0);
    chk("R1 reset free",  bus_free,   1'b1);
    rst_n = 1'b1;
    en = 1'b1;
    wait_cyc(SETTLE);
    check_all("R1 after enable");

    // R2 R4 R10: sweep all ordered pairs of wire levels
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        move(a[1], a[0], "R2 R10 sweep-from");
        pulse_clr("R7");
        move(b[1], b[0], "R2 R4 sweep-to");
        pulse_clr("R7");
      end
    end

    // R6: repeated opening condition
    move(1'b1, 1'b1, "R2 idle");
    move(1'b1, 1'b0, "R4 first open");
    pulse_clr("R6");
    move(1'b0, 1'b0, "R2 scl low");
    move(1'b0, 1'b1, "R2 sda under low scl");
    move(1'b1, 1'b1, "R2 scl high");
    move(1'b1, 1'b0, "R6 repeated open");
    chk("R6 start kept", start_seen, 1'b1);
    chk("R6 flag again", irq_flag, 1'b1);
    pulse_clr("R6");

    // R8: enable interrupt mid-transfer, request deferred to close
    irq_en = 1'b1;
    wait_cyc(2);
    chk("R8 no early irq", irq, 1'b0);
    move(1'b0, 1'b0, "R8 busy low");
    chk("R8 still no irq", irq, 1'b0);
    move(1'b1, 1'b0, "R8 scl up");
    move(1'b1, 1'b1, "R8 close");
    chk("R8 irq at close", irq, 1'b1);
    pulse_clr("R8");
    chk("R8 irq cleared", irq, 1'b0);

    // R5: byte strobe
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
    m_flag = 1'b1;
    chk("R5 byte flag", irq_flag, 1'b1);
    chk("R5 byte irq", irq, 1'b1);
    // R7: clear and byte together keeps flag
    @(negedge clk); byte_done = 1'b1; irq_clr = 1'b1;
    @(negedge clk); byte_done = 1'b0; irq_clr = 1'b0;
    chk("R7 set wins over clear", irq_flag, 1'b1);
    pulse_clr("R7");

    // R9: disabled block ignores the bus and the byte strobe
    move(1'b1, 1'b0, "R9 open before disable");
    @(negedge clk); en = 1'b0;
    m_open = 1'b0; m_close = 1'b0; m_flag = 1'b0;
    @(negedge clk);
    check_all("R9 disable clears");
    move(1'b1, 1'b1, "R9 close ignored");
    move(1'b1, 1'b0, "R9 open ignored");
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
    chk("R9 byte ignored", irq_flag, 1'b0);
    @(negedge clk); en = 1'b1;
    wait_cyc(2);
    check_all("R9 re-enable idle");
    move(1'b1, 1'b1, "R2 R4 close after enable");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule